// File: doc/BRIEF.md
# Per-Bank Open-Row Tracker

This block keeps track of the eight banks of an SDRAM device for a memory controller. The controller issues at most one precharge or activate per cycle. For every bank the block holds a short settling history of open and closed states, the row that was last activated, and a write-recovery countdown. From that state it reports which banks are fully open, which are fully closed, which have recovered from their last write, and whether a given request can be served from an open row without a bank command first.

In each cycle the controller presents candidate events: a demand precharge or demand activate for the request at the head of its pipeline, a read/write, a speculative precharge or activate for the bank after the current one, and a maintenance override used during initialisation and refresh. The block applies exactly one of them, chosen by fixed priority. The history registers model the three-clock latency of precharge and activate, so that a bank is neither reported open while its activate settles nor reported closed while its precharge completes. A small helper gives the next sequential bank and row for speculative work. The row advances when the bank index wraps past the last bank.

Top module: `bank_row_tracker`

## Requirements
- R1: After reset, `open_o` is all zeros, `closed_o` is all ones and `recovered_o` is all ones.
- R2: An activate to bank b that wins arbitration in cycle c drives `closed_o[b]` low from cycle c+1 and `open_o[b]` high from cycle c+3, unless a later event on b intervenes.
- R3: A precharge to bank b that wins arbitration in cycle c drives `open_o[b]` low from cycle c+1 and `closed_o[b]` high from cycle c+2.
- R4: `maint_i` high in cycle c forces `open_o` to all zeros and `closed_o` to all ones in cycle c+1, whatever other events are present.
- R5: No bank is ever reported open and closed in the same cycle.
- R6: A write (`rw_we_i`=1) that wins in cycle c drives `recovered_o[b]` low for cycles c+1 to c+7 and high again from c+8. A read that wins drives it high from c+1. A bank is recovered when its countdown is 1 or 0.
- R7: `hit_o` is high exactly when bank `req_bank_i` is open, its stored row equals `req_row_i`, and either `req_we_i` is 1 or the bank has recovered.
- R8: A bank stores the row given with an activate that wins arbitration, from a demand activate or a speculative one, from the next cycle on.
- R9: When several events are present in one cycle, only the first in this order takes effect: maintenance, demand precharge, demand activate, read/write, speculative precharge, speculative activate.
- R10: `next_bank_o` is `req_bank_i`+1 modulo 8. `next_row_o` is `req_row_i`+1 (modulo 2^14) when `req_bank_i` is 7, else `req_row_i`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| maint_i | input | 1 | Maintenance override: close every bank |
| dem_pre_i | input | 1 | Demand precharge request |
| dem_act_i | input | 1 | Demand activate request |
| dem_bank_i | input | 3 | Bank for demand precharge/activate |
| dem_row_i | input | 14 | Row for demand activate |
| rw_i | input | 1 | Read/write command issued |
| rw_we_i | input | 1 | 1 = write, 0 = read |
| rw_bank_i | input | 3 | Bank of the read/write |
| spec_pre_i | input | 1 | Speculative precharge request |
| spec_act_i | input | 1 | Speculative activate request |
| spec_bank_i | input | 3 | Bank for speculative precharge/activate |
| spec_row_i | input | 14 | Row for speculative activate |
| req_bank_i | input | 3 | Bank of the request being looked up |
| req_row_i | input | 14 | Row of the request being looked up |
| req_we_i | input | 1 | Looked-up request is a write |
| open_o | output | 8 | Per-bank settled-open flags |
| closed_o | output | 8 | Per-bank settled-closed flags |
| recovered_o | output | 8 | Per-bank write-recovered flags |
| hit_o | output | 1 | Request hits an open row |
| next_bank_o | output | 3 | Next sequential bank |
| next_row_o | output | 14 | Row that goes with the next bank |

## Verification
The lookup outputs `hit_o`, `next_bank_o` and `next_row_o` are combinational, so the bench checks them a short delay after it drives the request inputs in the same cycle. An event presented in cycle c is registered at the end of c. The bench therefore compares the flag outputs at the falling edge of c+1 against a model that it advances at each rising edge. Directed sequences then count falling edges to confirm that closed drops one cycle after an activate and open appears two cycles later, that closed returns two cycles after a precharge, and that the write-recovery window lasts exactly seven cycles.

// File: rtl/brt_pkg.sv
package brt_pkg;
  typedef enum logic [2:0] {
    EV_NONE  = 3'd0,
    EV_MAINT = 3'd1,
    EV_DPRE  = 3'd2,
    EV_DACT  = 3'd3,
    EV_RW    = 3'd4,
    EV_SPRE  = 3'd5,
    EV_SACT  = 3'd6
  } brt_event_e;
endpackage

// File: rtl/brt_arbiter.sv
module brt_arbiter
  import brt_pkg::*;
#(
  parameter int BANK_W = 3,
  parameter int ROW_W  = 14
) (
  input  logic              maint_i,
  input  logic              dem_pre_i,
  input  logic              dem_act_i,
  input  logic [BANK_W-1:0] dem_bank_i,
  input  logic [ROW_W-1:0]  dem_row_i,
  input  logic              rw_i,
  input  logic [BANK_W-1:0] rw_bank_i,
  input  logic              spec_pre_i,
  input  logic              spec_act_i,
  input  logic [BANK_W-1:0] spec_bank_i,
  input  logic [ROW_W-1:0]  spec_row_i,
  output brt_event_e        ev_o,
  output logic [BANK_W-1:0] ev_bank_o,
  output logic [ROW_W-1:0]  ev_row_o
);
  // Fixed priority, highest first (R9).
  always_comb begin
    ev_o      = EV_NONE;
    ev_bank_o = '0;
    ev_row_o  = '0;
    if (maint_i) begin
      ev_o = EV_MAINT;
    end else if (dem_pre_i) begin
      ev_o      = EV_DPRE;
      ev_bank_o = dem_bank_i;
    end else if (dem_act_i) begin
      ev_o      = EV_DACT;
      ev_bank_o = dem_bank_i;
      ev_row_o  = dem_row_i;
    end else if (rw_i) begin
      ev_o      = EV_RW;
      ev_bank_o = rw_bank_i;
    end else if (spec_pre_i) begin
      ev_o      = EV_SPRE;
      ev_bank_o = spec_bank_i;
    end else if (spec_act_i) begin
      ev_o      = EV_SACT;
      ev_bank_o = spec_bank_i;
      ev_row_o  = spec_row_i;
    end
  end
endmodule

// File: rtl/brt_bank.sv
module brt_bank #(
  parameter int HIST_W  = 4,
  parameter int ROW_W   = 14,
  parameter int CNT_W   = 4,
  parameter int WR_LOAD = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             maint_i,
  input  logic             pre_i,
  input  logic             act_i,
  input  logic             wr_i,
  input  logic             rd_i,
  input  logic [ROW_W-1:0] row_i,
  output logic             open_o,
  output logic             closed_o,
  output logic             recovered_o,
  output logic [ROW_W-1:0] row_o
);
  logic [HIST_W-1:0] hist_q, hist_d;
  logic              open_q, open_d;
  logic              closed_q, closed_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [ROW_W-1:0]  row_q;

  // Settling history: shift every clock, new bit from the event.
  always_comb begin
    hist_d = {hist_q[HIST_W-2:0], hist_q[0]};
    if (maint_i || pre_i) hist_d[0] = 1'b0;
    else if (act_i)       hist_d[0] = 1'b1;
  end

  always_comb begin
    open_d   = (hist_q[1:0] == 2'b11);
    closed_d = ~hist_q[0];
    if (maint_i) begin
      open_d   = 1'b0;
      closed_d = 1'b1;
    end else if (pre_i) begin
      open_d = 1'b0;
    end else if (act_i) begin
      closed_d = 1'b0;
    end
  end

  always_comb begin
    cnt_d = (cnt_q != '0) ? cnt_q - 1'b1 : '0;
    if (wr_i)      cnt_d = CNT_W'(WR_LOAD);
    else if (rd_i) cnt_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q   <= '0;
      open_q   <= 1'b0;
      closed_q <= 1'b1;
      cnt_q    <= '0;
    end else begin
      hist_q   <= hist_d;
      open_q   <= open_d;
      closed_q <= closed_d;
      cnt_q    <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     row_q <= '0;
    else if (act_i) row_q <= row_i;
  end

  assign open_o      = open_q;
  assign closed_o    = closed_q;
  assign recovered_o = (cnt_q[CNT_W-1:1] == '0);
  assign row_o       = row_q;
endmodule

// File: rtl/brt_next.sv
module brt_next #(
  parameter int BANK_W = 3,
  parameter int ROW_W  = 14
) (
  input  logic [BANK_W-1:0] bank_i,
  input  logic [ROW_W-1:0]  row_i,
  output logic [BANK_W-1:0] bank_o,
  output logic [ROW_W-1:0]  row_o
);
  always_comb begin
    bank_o = bank_i + 1'b1;
    row_o  = (&bank_i) ? row_i + 1'b1 : row_i;
  end
endmodule

// File: rtl/bank_row_tracker.sv
module bank_row_tracker
  import brt_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  parameter int ROW_W     = 14,
  parameter int HIST_W    = 4,
  parameter int WR_RECOV  = 8,
  localparam int BANK_W   = $clog2(NUM_BANKS),
  localparam int CNT_W    = $clog2(WR_RECOV + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 maint_i,
  input  logic                 dem_pre_i,
  input  logic                 dem_act_i,
  input  logic [BANK_W-1:0]    dem_bank_i,
  input  logic [ROW_W-1:0]     dem_row_i,
  input  logic                 rw_i,
  input  logic                 rw_we_i,
  input  logic [BANK_W-1:0]    rw_bank_i,
  input  logic                 spec_pre_i,
  input  logic                 spec_act_i,
  input  logic [BANK_W-1:0]    spec_bank_i,
  input  logic [ROW_W-1:0]     spec_row_i,
  input  logic [BANK_W-1:0]    req_bank_i,
  input  logic [ROW_W-1:0]     req_row_i,
  input  logic                 req_we_i,
  output logic [NUM_BANKS-1:0] open_o,
  output logic [NUM_BANKS-1:0] closed_o,
  output logic [NUM_BANKS-1:0] recovered_o,
  output logic                 hit_o,
  output logic [BANK_W-1:0]    next_bank_o,
  output logic [ROW_W-1:0]     next_row_o
);
  brt_event_e        ev;
  logic [BANK_W-1:0] ev_bank;
  logic [ROW_W-1:0]  ev_row;
  logic [ROW_W-1:0]  row_q [NUM_BANKS];

  brt_arbiter #(.BANK_W(BANK_W), .ROW_W(ROW_W)) u_arb (
    .maint_i(maint_i), .dem_pre_i(dem_pre_i), .dem_act_i(dem_act_i),
    .dem_bank_i(dem_bank_i), .dem_row_i(dem_row_i),
    .rw_i(rw_i), .rw_bank_i(rw_bank_i),
    .spec_pre_i(spec_pre_i), .spec_act_i(spec_act_i),
    .spec_bank_i(spec_bank_i), .spec_row_i(spec_row_i),
    .ev_o(ev), .ev_bank_o(ev_bank), .ev_row_o(ev_row)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic sel;
    assign sel = (ev_bank == BANK_W'(b));
    brt_bank #(
      .HIST_W(HIST_W), .ROW_W(ROW_W), .CNT_W(CNT_W), .WR_LOAD(WR_RECOV)
    ) u_bank (
      .clk(clk), .rst_n(rst_n),
      .maint_i(ev == EV_MAINT),
      .pre_i(sel && (ev == EV_DPRE || ev == EV_SPRE)),
      .act_i(sel && (ev == EV_DACT || ev == EV_SACT)),
      .wr_i(sel && (ev == EV_RW) && rw_we_i),
      .rd_i(sel && (ev == EV_RW) && !rw_we_i),
      .row_i(ev_row),
      .open_o(open_o[b]),
      .closed_o(closed_o[b]),
      .recovered_o(recovered_o[b]),
      .row_o(row_q[b])
    );
  end

  assign hit_o = open_o[req_bank_i] && (row_q[req_bank_i] == req_row_i) &&
                 (req_we_i || recovered_o[req_bank_i]);

  brt_next #(.BANK_W(BANK_W), .ROW_W(ROW_W)) u_next (
    .bank_i(req_bank_i), .row_i(req_row_i),
    .bank_o(next_bank_o), .row_o(next_row_o)
  );
endmodule

// File: rtl/brt_checker.sv
module brt_checker #(
  parameter int NUM_BANKS = 8,
  parameter int BANK_W    = 3
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 maint_i,
  input logic                 dem_pre_i,
  input logic                 dem_act_i,
  input logic [BANK_W-1:0]    dem_bank_i,
  input logic                 rw_i,
  input logic                 rw_we_i,
  input logic [BANK_W-1:0]    rw_bank_i,
  input logic [BANK_W-1:0]    req_bank_i,
  input logic                 req_we_i,
  input logic [NUM_BANKS-1:0] open_o,
  input logic [NUM_BANKS-1:0] closed_o,
  input logic [NUM_BANKS-1:0] recovered_o,
  input logic                 hit_o
);
  p_act_clears_closed_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (dem_act_i && !maint_i && !dem_pre_i) |=> !closed_o[$past(dem_bank_i)]);

  p_pre_clears_open_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (dem_pre_i && !maint_i) |=> !open_o[$past(dem_bank_i)]);

  p_maint_closes_all_r4: assert property (@(posedge clk) disable iff (!rst_n)
    maint_i |=> (open_o == '0) && (closed_o == '1));

  p_open_closed_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (open_o & closed_o) == '0);

  p_write_blocks_recovery_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rw_i && rw_we_i && !maint_i && !dem_pre_i && !dem_act_i)
      |=> !recovered_o[$past(rw_bank_i)]);

  p_hit_needs_open_r7: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o |-> open_o[req_bank_i]);

  p_read_hit_recovered_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_o && !req_we_i) |-> recovered_o[req_bank_i]);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_settle
    // Open can only appear after the bank had already left closed (R2).
    p_open_after_settle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(open_o[b]) |-> !$past(closed_o[b]));
  end
endmodule

bind bank_row_tracker brt_checker #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .maint_i(maint_i), .dem_pre_i(dem_pre_i),
  .dem_act_i(dem_act_i), .dem_bank_i(dem_bank_i), .rw_i(rw_i),
  .rw_we_i(rw_we_i), .rw_bank_i(rw_bank_i), .req_bank_i(req_bank_i),
  .req_we_i(req_we_i), .open_o(open_o), .closed_o(closed_o),
  .recovered_o(recovered_o), .hit_o(hit_o)
);

// File: tb/bank_row_tracker_test.sv
module bank_row_tracker_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        maint_i = 0, dem_pre_i = 0, dem_act_i = 0;
  logic [2:0]  dem_bank_i = 0;
  logic [13:0] dem_row_i = 0;
  logic        rw_i = 0, rw_we_i = 0;
  logic [2:0]  rw_bank_i = 0;
  logic        spec_pre_i = 0, spec_act_i = 0;
  logic [2:0]  spec_bank_i = 0;
  logic [13:0] spec_row_i = 0;
  logic [2:0]  req_bank_i = 0;
  logic [13:0] req_row_i = 0;
  logic        req_we_i = 0;
  logic [7:0]  open_o, closed_o, recovered_o;
  logic        hit_o;
  logic [2:0]  next_bank_o;
  logic [13:0] next_row_o;

  int n_chk = 0;
  int n_fail = 0;

  // Model state (R1 reset values)
  logic        m_lo [8];
  logic        m_lo1 [8];
  logic        m_open [8];
  logic        m_closed [8];
  int          m_cnt [8];
  logic [13:0] m_row [8];

  bank_row_tracker uut (.*);

  always #5 clk = ~clk;

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int b = 0; b < 8; b++) begin
      m_lo[b] = 0; m_lo1[b] = 0; m_open[b] = 0; m_closed[b] = 1;
      m_cnt[b] = 0; m_row[b] = '0;
    end
  endtask

  function automatic bit m_rec(input int b);
    return m_cnt[b] <= 1;
  endfunction

  // Priority selection per R9: 0 none,1 maint,2 dpre,3 dact,4 rw,5 spre,6 sact
  function automatic int winner();
    if (maint_i) return 1;
    if (dem_pre_i) return 2;
    if (dem_act_i) return 3;
    if (rw_i) return 4;
    if (spec_pre_i) return 5;
    if (spec_act_i) return 6;
    return 0;
  endfunction

  task automatic model_edge();
    int w;
    int wb;
    w = winner();
    wb = (w == 2 || w == 3) ? int'(dem_bank_i) : (w == 4) ? int'(rw_bank_i) :
         (w >= 5) ? int'(spec_bank_i) : -1;
    for (int b = 0; b < 8; b++) begin
      bit pre, act;
      logic no, nc, nl;
      pre = (b == wb) && (w == 2 || w == 5);
      act = (b == wb) && (w == 3 || w == 6);
      no = m_lo[b] & m_lo1[b];
      nc = ~m_lo[b];
      nl = m_lo[b];
      if (w == 1) begin no = 0; nc = 1; nl = 0; end
      else if (pre) begin no = 0; nl = 0; end
      else if (act) begin nc = 0; nl = 1; end
      m_lo1[b] = m_lo[b]; m_lo[b] = nl; m_open[b] = no; m_closed[b] = nc;
      if (m_cnt[b] > 0) m_cnt[b]--;
      if (w == 4 && b == wb) m_cnt[b] = rw_we_i ? 8 : 0;
      if (act) m_row[b] = (w == 3) ? dem_row_i : spec_row_i;
    end
  endtask

  task automatic check_comb();
    bit eh;
    logic [2:0] enb;
    logic [13:0] enr;
    int rb;
    rb = int'(req_bank_i);
    eh = m_open[rb] && (m_row[rb] == req_row_i) && (req_we_i || m_rec(rb));
    check(hit_o == eh, "R7 hit", hit_o, eh);
    enb = req_bank_i + 3'd1;
    enr = (req_bank_i == 3'd7) ? req_row_i + 14'd1 : req_row_i;
    check(next_bank_o == enb && next_row_o == enr, "R10 next bank/row",
          {next_bank_o, next_row_o}, {enb, enr});
  endtask

  task automatic check_regs();
    logic [7:0] eo, ec, er;
    for (int b = 0; b < 8; b++) begin
      eo[b] = m_open[b]; ec[b] = m_closed[b]; er[b] = m_rec(b);
    end
    check(open_o == eo, "R2/R9 open flags", open_o, eo);
    check(closed_o == ec, "R3/R9 closed flags", closed_o, ec);
    check(recovered_o == er, "R6 recovered flags", recovered_o, er);
    check((open_o & closed_o) == 8'h0, "R5 exclusive", open_o & closed_o, 0);
  endtask

  // Inputs are set at a falling edge before calling.
  task automatic step();
    #1 check_comb();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check_regs();
  endtask

  task automatic idle();
    maint_i = 0; dem_pre_i = 0; dem_act_i = 0; rw_i = 0; rw_we_i = 0;
    spec_pre_i = 0; spec_act_i = 0;
  endtask

  initial begin
    #(200000 * 10);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(open_o == 8'h00, "R1 open after reset", open_o, 8'h00);
    check(closed_o == 8'hff, "R1 closed after reset", closed_o, 8'hff);
    check(recovered_o == 8'hff, "R1 recovered after reset", recovered_o, 8'hff);

    // R2/R8: demand activate bank 2 row 9, settling timing
    dem_act_i = 1; dem_bank_i = 2; dem_row_i = 14'd9;
    step(); idle();
    check(closed_o[2] == 0, "R2 closed drops c+1", closed_o[2], 0);
    check(open_o[2] == 0, "R2 not open at c+1", open_o[2], 0);
    step();
    check(open_o[2] == 0, "R2 not open at c+2", open_o[2], 0);
    step();
    check(open_o[2] == 1, "R2 open at c+3", open_o[2], 1);
    req_bank_i = 2; req_row_i = 14'd9; req_we_i = 0;
    #1 check(hit_o == 1, "R8 demand row stored hit", hit_o, 1);
    req_row_i = 14'd10;
    #1 check(hit_o == 0, "R7 row mismatch miss", hit_o, 0);

    // R6: write recovery window on bank 2
    @(negedge clk);
    rw_i = 1; rw_we_i = 1; rw_bank_i = 2;
    step(); idle();
    for (int k = 1; k <= 7; k++) begin
      check(recovered_o[2] == 0, "R6 recovery window", recovered_o[2], 0);
      if (k == 3) begin
        req_bank_i = 2; req_row_i = 14'd9; req_we_i = 0;
        #1 check(hit_o == 0, "R7 read blocked while recovering", hit_o, 0);
        req_we_i = 1;
        #1 check(hit_o == 1, "R7 write hits while recovering", hit_o, 1);
        req_we_i = 0;
      end
      step();
    end
    check(recovered_o[2] == 1, "R6 recovered at c+8", recovered_o[2], 1);

    // R3: precharge bank 2
    dem_pre_i = 1; dem_bank_i = 2;
    step(); idle();
    check(open_o[2] == 0, "R3 open drops c+1", open_o[2], 0);
    check(closed_o[2] == 0, "R3 not closed at c+1", closed_o[2], 0);
    step();
    check(closed_o[2] == 1, "R3 closed at c+2", closed_o[2], 1);

    // R9: demand activate beats speculative activate
    dem_act_i = 1; dem_bank_i = 3; dem_row_i = 14'd1;
    spec_act_i = 1; spec_bank_i = 4; spec_row_i = 14'd2;
    step(); idle();
    check(closed_o[3] == 0 && closed_o[4] == 1, "R9 dem act over spec act",
          {closed_o[3], closed_o[4]}, 2'b01);
    // R9: demand precharge beats read/write and demand activate
    dem_pre_i = 1; dem_act_i = 1; dem_bank_i = 5;
    rw_i = 1; rw_we_i = 1; rw_bank_i = 6;
    step(); idle();
    check(recovered_o[6] == 1 && closed_o[5] == 1, "R9 pre over rw/act",
          {recovered_o[6], closed_o[5]}, 2'b11);

    // R8: speculative activate records row
    spec_act_i = 1; spec_bank_i = 6; spec_row_i = 14'h123;
    step(); idle(); step(); step();
    req_bank_i = 6; req_row_i = 14'h123; req_we_i = 0;
    #1 check(hit_o == 1, "R8 speculative row stored hit", hit_o, 1);

    // R4: maintenance overrides a demand activate
    @(negedge clk);
    maint_i = 1; dem_act_i = 1; dem_bank_i = 0;
    step(); idle();
    check(open_o == 8'h00 && closed_o == 8'hff, "R4 maintenance closes all",
          {open_o, closed_o}, 16'h00ff);

    // R10 corner cases
    req_bank_i = 7; req_row_i = 14'h3fff;
    #1 check(next_bank_o == 0 && next_row_o == 0, "R10 wrap bank and row",
             {next_bank_o, next_row_o}, 17'h0);
    req_bank_i = 3; req_row_i = 14'h3fff;
    #1 check(next_bank_o == 4 && next_row_o == 14'h3fff, "R10 no row step",
             {next_bank_o, next_row_o}, {3'd4, 14'h3fff});
    @(negedge clk);

    // Random mix
    for (int i = 0; i < 3000; i++) begin
      maint_i     = ($urandom_range(0, 59) == 0);
      dem_pre_i   = ($urandom_range(0, 5) == 0);
      dem_act_i   = ($urandom_range(0, 3) == 0);
      dem_bank_i  = 3'($urandom_range(0, 7));
      dem_row_i   = 14'($urandom_range(0, 3));
      rw_i        = ($urandom_range(0, 2) == 0);
      rw_we_i     = ($urandom_range(0, 1) == 0);
      rw_bank_i   = 3'($urandom_range(0, 7));
      spec_pre_i  = ($urandom_range(0, 5) == 0);
      spec_act_i  = ($urandom_range(0, 3) == 0);
      spec_bank_i = 3'($urandom_range(0, 7));
      spec_row_i  = 14'($urandom_range(0, 3));
      req_bank_i  = 3'($urandom_range(0, 7));
      req_row_i   = ($urandom_range(0, 15) == 0) ? 14'($urandom_range(0, 16383))
                                                  : 14'($urandom_range(0, 3));
      req_we_i    = ($urandom_range(0, 1) == 0);
      step();
    end
    idle();

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule